// File: doc/BRIEF.md
# Grouped Interrupt Status Aggregator

This block gathers twenty-four single-cycle event pulses from the functions of a power-management device. It keeps them as sticky status bits in three byte-wide registers. Each bit has two mask bits. A latch-mask bit decides whether the event is recorded at all. A line-mask bit decides whether a recorded bit may drive the shared, active-high interrupt output. The block also folds the status bits into ten per-function summary lines, so a handler can tell at once which function needs service.

Software uses a byte-wide register port whose address pointer advances by one after every access. A service routine reads the three status bytes as one burst from offset 0x00. It acknowledges the events by writing the same bytes back, because a 1 written to a status bit clears it. At reset every line mask is set, so the output line stays quiet until software opens selected bits with a read-modify-write.

Top module: `irq_group_agg`

## Requirements
- R1: After reset every status bit is 0, every line-mask bit is 1, every latch-mask bit is 0, the pointer is 0, and irqOut and all of groupIrq are 0.
- R2: A pulse on evtIn[i] whose latch-mask bit is 0 sets status bit i at that clock edge. The bit then stays set until it is cleared.
- R3: While latch-mask bit i is 1, a pulse on evtIn[i] leaves status bit i unchanged.
- R4: irqOut is the OR over all bits of (status AND NOT line-mask). The line mask has no effect on the status bits.
- R5: A write to a status byte clears each status bit whose data bit is 1 and leaves the other bits unchanged.
- R6: When an event pulse and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R7: Status bit 7 (offset 0x00, data bit 7) always reads 0. Events on evtIn[7] and writes to that bit have no effect.
- R8: groupIrq[g] is the OR of (status AND NOT line-mask) over the bits of its group: g0 = bits 0-3, g1 = 4-5, g2 = 6, g3 = 8-10, g4 = 11, g5 = 12, g6 = 13-14, g7 = 15, g8 = 16-19, g9 = 20-23.
- R9: An access with accFirst=1 uses accAddr as its offset. An access with accFirst=0 uses the pointer. Each access sets the pointer to its offset plus one, modulo 16. accRdata shows the byte at the current offset in the same cycle.
- R10: Offsets 0x09 to 0x0F read 0x00, and writes to them change no register.
- R11: Offsets 0x00-0x02 hold status bits 0-7, 8-15 and 16-23. Offsets 0x03-0x05 hold the line masks for the same bits, and offsets 0x06-0x08 hold the latch masks. Mask bytes read back exactly what was written last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 24 | Event pulses, one bit per source |
| accValid | input | 1 | A register access happens this cycle |
| accWrite | input | 1 | The access is a write (1) or a read (0) |
| accFirst | input | 1 | Take the offset from accAddr instead of the pointer |
| accAddr | input | 4 | Start offset of a burst |
| accWdata | input | 8 | Write data |
| accRdata | output | 8 | Read data at the current offset |
| irqOut | output | 1 | Shared interrupt line, active high |
| groupIrq | output | 10 | Per-group summary interrupts |

## Verification
The assertions assume that evtIn carries pulses sampled at the clock edge, and that a register access lasts one cycle with its fields stable at that edge. The bench drives every input at the falling edge to meet this. It mixes sparse random event bursts with random reads and writes at every offset, including the unused ones. Directed sequences cover the collision of set and clear, the reserved bit and the group sweep. With all line masks open after the initial unmask, most random cycles exercise the output line and the summary outputs.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = 3;
  localparam int EVT_W      = BYTE_W * NUM_BYTES;
  localparam int NUM_GROUPS = 10;
  localparam int OFF_W      = 4;
  localparam int RESV_BIT   = 7;

  localparam logic [OFF_W-1:0] OFF_STS  = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_LMSK = OFF_W'(NUM_BYTES);
  localparam logic [OFF_W-1:0] OFF_SMSK = OFF_W'(2 * NUM_BYTES);

  typedef struct packed {
    logic [NUM_BYTES-1:0] clrSts;
    logic [NUM_BYTES-1:0] wrLine;
    logic [NUM_BYTES-1:0] wrSmsk;
    logic [OFF_W-1:0]     rdOff;
  } dpStrobe_t;

  // Status bits that feed each summary group
  function automatic logic [EVT_W-1:0] groupBits(input int g);
    logic [EVT_W-1:0] m;
    case (g)
      0:       m = EVT_W'(24'h00000F);
      1:       m = EVT_W'(24'h000030);
      2:       m = EVT_W'(24'h000040);
      3:       m = EVT_W'(24'h000700);
      4:       m = EVT_W'(24'h000800);
      5:       m = EVT_W'(24'h001000);
      6:       m = EVT_W'(24'h006000);
      7:       m = EVT_W'(24'h008000);
      8:       m = EVT_W'(24'h0F0000);
      9:       m = EVT_W'(24'hF00000);
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic             accFirst,
  input  logic [OFF_W-1:0] accAddr,
  output dpStrobe_t        strobe
);
  logic [OFF_W-1:0] ptr;
  logic [OFF_W-1:0] effOff;

  assign effOff = accFirst ? accAddr : ptr;

  // Decode the effective offset into per-byte write strobes
  always_comb begin
    strobe       = '0;
    strobe.rdOff = effOff;
    if (accValid && accWrite) begin
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (effOff == OFF_STS  + OFF_W'(k)) strobe.clrSts[k] = 1'b1;
        if (effOff == OFF_LMSK + OFF_W'(k)) strobe.wrLine[k] = 1'b1;
        if (effOff == OFF_SMSK + OFF_W'(k)) strobe.wrSmsk[k] = 1'b1;
      end
    end
  end

  // Burst pointer: every access advances past its own offset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ptr <= '0;
    else if (accValid) ptr <= effOff + OFF_W'(1);
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic [EVT_W-1:0]      evtIn,
  output logic [BYTE_W-1:0]     rdata,
  output logic                  irqOut,
  output logic [NUM_GROUPS-1:0] groupIrq
);
  localparam logic [EVT_W-1:0] RESV_MASK = EVT_W'(1) << RESV_BIT;

  logic [EVT_W-1:0] stat;
  logic [EVT_W-1:0] lineMsk;
  logic [EVT_W-1:0] stsMsk;
  logic [EVT_W-1:0] clrVec;
  logic [EVT_W-1:0] pend;

  for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
    assign clrVec[k*BYTE_W +: BYTE_W] = strobe.clrSts[k] ? wdata : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                lineMsk[k*BYTE_W +: BYTE_W] <= '1;
      else if (strobe.wrLine[k]) lineMsk[k*BYTE_W +: BYTE_W] <= wdata;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                stsMsk[k*BYTE_W +: BYTE_W] <= '0;
      else if (strobe.wrSmsk[k]) stsMsk[k*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  // Set takes priority over clear; the reserved bit never latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stat <= '0;
    else       stat <= ((stat & ~clrVec) | (evtIn & ~stsMsk)) & ~RESV_MASK;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (strobe.rdOff == OFF_STS  + OFF_W'(k)) rdata = stat[k*BYTE_W +: BYTE_W];
      if (strobe.rdOff == OFF_LMSK + OFF_W'(k)) rdata = lineMsk[k*BYTE_W +: BYTE_W];
      if (strobe.rdOff == OFF_SMSK + OFF_W'(k)) rdata = stsMsk[k*BYTE_W +: BYTE_W];
    end
  end

  assign pend   = stat & ~lineMsk;
  assign irqOut = |pend;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign groupIrq[g] = |(pend & groupBits(g));
  end
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import irq_agg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [EVT_W-1:0]      evtIn,
  input  logic                  accValid,
  input  logic                  accWrite,
  input  logic                  accFirst,
  input  logic [OFF_W-1:0]      accAddr,
  input  logic [BYTE_W-1:0]     accWdata,
  output logic [BYTE_W-1:0]     accRdata,
  output logic                  irqOut,
  output logic [NUM_GROUPS-1:0] groupIrq
);
  dpStrobe_t strobe;

  irq_agg_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accWrite (accWrite),
    .accFirst (accFirst),
    .accAddr  (accAddr),
    .strobe   (strobe)
  );

  irq_agg_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (accWdata),
    .evtIn    (evtIn),
    .rdata    (accRdata),
    .irqOut   (irqOut),
    .groupIrq (groupIrq)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic [EVT_W-1:0]      evtIn,
  input logic                  accValid,
  input logic                  accWrite,
  input logic                  accFirst,
  input logic [OFF_W-1:0]      accAddr,
  input logic [BYTE_W-1:0]     accWdata,
  input logic                  irqOut,
  input logic [NUM_GROUPS-1:0] groupIrq,
  input logic [EVT_W-1:0]      stat,
  input logic [EVT_W-1:0]      stsMsk,
  input logic [OFF_W-1:0]      ptr
);
  localparam logic [EVT_W-1:0] RESV_MASK = EVT_W'(1) << RESV_BIT;

  logic [EVT_W-1:0] setReq;
  logic [OFF_W-1:0] effOff;
  assign setReq = evtIn & ~stsMsk & ~RESV_MASK;
  assign effOff = accFirst ? accAddr : ptr;

  // R2, R6: an unmasked event is recorded, even when it is also being cleared
  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stat & $past(setReq)) == $past(setReq)));

  // R3: a bit can only rise because an unmasked event asked for it
  p_masked_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(setReq)) == '0));

  // R4: the shared line agrees with the group summaries
  p_line_vs_groups_r4: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (groupIrq != '0));

  // R5: bits written with 1 at offset 0 and not re-raised are gone
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && effOff == OFF_STS)
    |=> ((stat[BYTE_W-1:0] & $past(accWdata & ~evtIn[BYTE_W-1:0])) == '0));

  // R7: the reserved bit never holds a 1
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    stat[RESV_BIT] == 1'b0);

  // R9: every access moves the pointer one past its offset
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> (ptr == $past(effOff) + OFF_W'(1)));
endmodule

bind irq_group_agg irq_agg_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .evtIn    (evtIn),
  .accValid (accValid),
  .accWrite (accWrite),
  .accFirst (accFirst),
  .accAddr  (accAddr),
  .accWdata (accWdata),
  .irqOut   (irqOut),
  .groupIrq (groupIrq),
  .stat     (uDp.stat),
  .stsMsk   (uDp.stsMsk),
  .ptr      (uCtrl.ptr)
);

// File: tb/sim_irq_group_agg.sv
`timescale 1ns/1ps
module sim_irq_group_agg;
  logic        clk = 1'b0;
  logic        rstN;
  logic [23:0] evtIn;
  logic        accValid, accWrite, accFirst;
  logic [3:0]  accAddr;
  logic [7:0]  accWdata;
  logic [7:0]  accRdata;
  logic        irqOut;
  logic [9:0]  groupIrq;

  int nVec = 0;
  int nErr = 0;

  // Reference model state
  logic [23:0] mSts, mLine, mSmsk;
  logic [3:0]  mPtr;

  always #4 clk = ~clk;

  irq_group_agg u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .accValid(accValid),
    .accWrite(accWrite), .accFirst(accFirst), .accAddr(accAddr),
    .accWdata(accWdata), .accRdata(accRdata), .irqOut(irqOut),
    .groupIrq(groupIrq)
  );

  function automatic logic [23:0] grpMask(input int g);
    case (g)
      0: return 24'h00000F;  1: return 24'h000030;
      2: return 24'h000040;  3: return 24'h000700;
      4: return 24'h000800;  5: return 24'h001000;
      6: return 24'h006000;  7: return 24'h008000;
      8: return 24'h0F0000;  9: return 24'hF00000;
      default: return 24'h0;
    endcase
  endfunction

  function automatic logic [9:0] expGroups();
    logic [9:0] r;
    for (int g = 0; g < 10; g++) r[g] = |(mSts & ~mLine & grpMask(g));
    return r;
  endfunction

  function automatic logic [7:0] expRead(input logic [3:0] off);
    case (off)
      4'd0: return mSts[7:0];   4'd1: return mSts[15:8];   4'd2: return mSts[23:16];
      4'd3: return mLine[7:0];  4'd4: return mLine[15:8];  4'd5: return mLine[23:16];
      4'd6: return mSmsk[7:0];  4'd7: return mSmsk[15:8];  4'd8: return mSmsk[23:16];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock cycle with optional access; checks read data and outputs
  task automatic cyc(input logic [23:0] ev, input bit v, input bit wr, input bit first,
                     input logic [3:0] a, input logic [7:0] d, input string tag);
    logic [3:0]  eff;
    logic [23:0] clr;
    @(negedge clk);
    evtIn = ev; accValid = v; accWrite = wr; accFirst = first; accAddr = a; accWdata = d;
    eff = first ? a : mPtr;
    #1;
    if (v && !wr) chk(tag, 32'(accRdata), 32'(expRead(eff)));
    @(posedge clk);
    clr = '0;
    if (v && wr) begin
      case (eff)
        4'd0: clr[7:0] = d;   4'd1: clr[15:8] = d;   4'd2: clr[23:16] = d;
        4'd3: mLine[7:0] = d; 4'd4: mLine[15:8] = d; 4'd5: mLine[23:16] = d;
        default: ;
      endcase
    end
    mSts = ((mSts & ~clr) | (ev & ~mSmsk)) & ~24'h000080;
    if (v && wr) begin
      case (eff)
        4'd6: mSmsk[7:0] = d; 4'd7: mSmsk[15:8] = d; 4'd8: mSmsk[23:16] = d;
        default: ;
      endcase
    end
    if (v) mPtr = eff + 4'd1;
    #1;
    chk("R4 irqOut", 32'(irqOut), 32'(|(mSts & ~mLine)));
    chk("R8 groupIrq", 32'(groupIrq), 32'(expGroups()));
  endtask

  task automatic idle(input logic [23:0] ev, input string tag);
    cyc(ev, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00, tag);
  endtask

  task automatic rd(input bit first, input logic [3:0] a, input string tag);
    cyc(24'h0, 1'b1, 1'b0, first, a, 8'h00, tag);
  endtask

  task automatic wr(input bit first, input logic [3:0] a, input logic [7:0] d, input string tag);
    cyc(24'h0, 1'b1, 1'b1, first, a, d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

  initial begin
    logic [7:0] tmp;
    void'($urandom(32'd20240611));
    rstN = 1'b0; evtIn = '0; accValid = 0; accWrite = 0; accFirst = 0; accAddr = '0; accWdata = '0;
    mSts = '0; mLine = '1; mSmsk = '0; mPtr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R1 irqOut", 32'(irqOut), 32'd0);
    chk("R1 groupIrq", 32'(groupIrq), 32'd0);

    // R1 and R9: burst through all nine registers, pointer starting at 0
    rd(1'b0, 4'd0, "R1 reset value");
    for (int i = 1; i < 9; i++) rd(1'b0, 4'd0, "R1 reset value");
    rd(1'b1, 4'd3, "R1 line mask FF");
    chk("R1 line mask reads FF", 32'(accRdata), 32'hFF);

    // R11: read-modify-write unmask of offset 4, then read back
    rd(1'b1, 4'd4, "R11 mask read");
    tmp = 8'hFF & ~8'h18;
    wr(1'b1, 4'd4, tmp, "R11 mask write");
    rd(1'b1, 4'd4, "R11 mask readback");
    chk("R11 mask readback", 32'(accRdata), 32'hE7);
    // Open all line masks with a burst write
    wr(1'b1, 4'd3, 8'h00, "R9 burst write");
    wr(1'b0, 4'd0, 8'h00, "R9 burst write");
    wr(1'b0, 4'd0, 8'h00, "R9 burst write");
    rd(1'b1, 4'd5, "R11 mask readback");

    // R2: an event latches and stays
    idle(24'h000001, "R2 event");
    idle(24'h000000, "R2 sticky");
    rd(1'b1, 4'd0, "R2 status byte");
    chk("R2 status bit 0 set", 32'(accRdata), 32'h01);
    chk("R2 irqOut high", 32'(irqOut), 32'd1);

    // R7: reserved bit ignores events and writes
    idle(24'h000080, "R7 reserved event");
    wr(1'b1, 4'd0, 8'h80, "R7 reserved write");
    rd(1'b1, 4'd0, "R7 reserved reads 0");
    chk("R7 bit 7 reads 0", 32'(accRdata & 8'h80), 32'h00);

    // R6: set wins over the clear in the same cycle
    cyc(24'h000001, 1'b1, 1'b1, 1'b1, 4'd0, 8'h01, "R6 collide");
    rd(1'b1, 4'd0, "R6 still set");
    chk("R6 bit 0 survives", 32'(accRdata), 32'h01);

    // R5: clear only the bits written with 1
    idle(24'h000006, "R5 set more");
    wr(1'b1, 4'd0, 8'h05, "R5 clear");
    rd(1'b1, 4'd0, "R5 result");
    chk("R5 only bit 1 left", 32'(accRdata), 32'h02);

    // R4: line mask drops output but keeps status
    wr(1'b1, 4'd3, 8'h02, "R4 mask bit 1");
    chk("R4 irqOut masked", 32'(irqOut), 32'd0);
    rd(1'b1, 4'd0, "R4 status kept");
    chk("R4 status kept", 32'(accRdata), 32'h02);
    wr(1'b1, 4'd3, 8'h00, "R4 unmask");
    chk("R4 irqOut returns", 32'(irqOut), 32'd1);
    wr(1'b1, 4'd0, 8'hFF, "R5 clear all");

    // R3: latch mask blocks bit 11
    wr(1'b1, 4'd7, 8'h08, "R3 set latch mask");
    idle(24'h000800, "R3 masked event");
    rd(1'b1, 4'd1, "R3 not latched");
    chk("R3 bit 11 not latched", 32'(accRdata), 32'h00);
    chk("R3 no interrupt", 32'(irqOut), 32'd0);
    wr(1'b1, 4'd7, 8'h00, "R3 clear latch mask");

    // R10: writes to unused offsets, then read them and all real registers
    wr(1'b1, 4'd9, 8'hFF, "R10 unused write");
    for (int i = 10; i < 16; i++) wr(1'b0, 4'd0, 8'hFF, "R10 unused write");
    rd(1'b1, 4'd9, "R10 unused reads 0");
    chk("R10 offset 9 reads 00", 32'(accRdata), 32'h00);
    for (int i = 10; i < 16; i++) rd(1'b0, 4'd0, "R10 unused reads 0");
    for (int i = 0; i < 9; i++) rd(1'b0, 4'd0, "R10 registers untouched");

    // R8: sweep each event through its group
    for (int b = 0; b < 24; b++) begin
      idle(24'(1) << b, "R8 group sweep");
      wr(1'b1, 4'd0, 8'hFF, "R8 clear");
      wr(1'b0, 4'd0, 8'hFF, "R8 clear");
      wr(1'b0, 4'd0, 8'hFF, "R8 clear");
    end

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] ev;
      ev = ($urandom % 4 == 0) ? 24'($urandom & $urandom & $urandom) : 24'h0;
      cyc(ev, ($urandom % 10) < 3, $urandom % 2 == 1, $urandom % 2 == 1,
          4'($urandom), 8'($urandom), "R9 random access");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule